// File: doc/BRIEF.md
# Bus Hold Arbiter with Pin Handover

This block lets an outside master borrow the processor's external memory bus. The outside master pulls an active-low request pin low. The block synchronises that pin and asks the CPU core to stop at its next instruction boundary. It asserts the active-low acknowledge only once the core reports that it has let go of the bus. While the hold lasts, the block drops the output enables of the address, memory-request and I/O-request pins, so that those pins act as inputs. It also floats the data, read, write and instruction-fetch pins. The address and strobe inputs coming from the pads are steered into the on-chip chip-select decoder. As a result, the chip-select outputs keep decoding for the outside master.

When the request pin returns high, the acknowledge is withdrawn first. The pin drivers come back one clock later, and the core is released in the same cycle as the drivers, so two masters never drive the bus at once. If the request goes away before the core has let go of the bus, the block returns the bus to the core without ever acknowledging.

The request input is a level signal; all other pins are plain control and status signals. No valid/ready handshake applies, because nothing streams through the block.

Top module: `bus_hold_arbiter`

## Requirements
- R1: During and after reset, with no request pending, `back_n`=1, `core_hold_req`=0, `dec_ext_sel`=0 and `addr_oe`, `strobe_oe`, `data_oe`, `cmd_oe` all equal 1.
- R2: `breq_n_pin` passes through a two-stage synchroniser. After `breq_n_pin` falls, `core_hold_req` rises on the third rising clock edge, and it is still 0 after the first and second edges.
- R3: `back_n` falls on the first rising edge at which `core_released`=1 while `core_hold_req`=1 and the request is still present. It never falls before the core has reported release.
- R4: While `back_n`=0, `addr_oe`=0 and `strobe_oe`=0, and `dec_ext_sel`=1. The decoder then takes `pad_addr_in`, `pad_mreq_n_in` and `pad_iorq_n_in` in place of the core's signals.
- R5: `cs_n[i]` is 0 exactly when all of the following hold: `cs_en[i]`=1; `(addr & cs_mask[i*AW +: AW]) == cs_base[i*AW +: AW]`; the strobe of the region's kind is low (`cs_io[i]`=1 selects the I/O request, 0 selects the memory request); and no lower index also matches. The decoder works combinationally in every state, so at most one `cs_n` bit is low.
- R6: While `back_n`=0, `data_oe`=0 and `cmd_oe`=0 (data, read, write and instruction-fetch pins floated). `cs_n` stays driven in every state.
- R7: After `breq_n_pin` rises during a grant, `back_n` rises on the third rising edge. The output enables stay 0 on that edge and become 1 on the next edge.
- R8: `core_hold_req` stays 1 through the cycle in which `back_n` has risen but the drivers are still off. It falls on the same edge at which the drivers are enabled again and `dec_ext_sel` returns to 0.
- R9: If the request is withdrawn while the block waits for the core, `back_n` stays 1 throughout. `core_hold_req` falls on the third rising edge after `breq_n_pin` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| breq_n_pin | input | 1 | Asynchronous active-low bus request from the outside master |
| back_n | output | 1 | Active-low bus acknowledge |
| core_hold_req | output | 1 | Asks the core to stop at the next instruction boundary and release the bus |
| core_released | input | 1 | Core reports that it has released the bus |
| core_addr | input | AW | Core address |
| core_mreq_n | input | 1 | Core memory request strobe, active low |
| core_iorq_n | input | 1 | Core I/O request strobe, active low |
| pad_addr_in | input | AW | Address seen at the pads |
| pad_mreq_n_in | input | 1 | Memory request seen at the pad |
| pad_iorq_n_in | input | 1 | I/O request seen at the pad |
| cs_base | input | NCS*AW | Base address of each chip-select region |
| cs_mask | input | NCS*AW | Compare mask of each chip-select region |
| cs_io | input | NCS | 1 = the region answers to I/O requests, 0 = to memory requests |
| cs_en | input | NCS | Enables each region |
| addr_oe | output | 1 | Output enable of the address pins |
| strobe_oe | output | 1 | Output enable of the memory-request and I/O-request pins |
| data_oe | output | 1 | Drive permission of the data pins |
| cmd_oe | output | 1 | Output enable of the read, write and instruction-fetch pins |
| dec_ext_sel | output | 1 | 1 = the decoder is fed from the pads |
| cs_n | output | NCS | Active-low chip selects |

## Verification
A state register stuck in the wrong place shows within one clock as a mismatch between `back_n`, `core_hold_req` and the four enables. One example is an acknowledge without the floated pins. Another is drivers returning in the same cycle that the acknowledge drops. A wrong source select shows immediately in `cs_n`, because the bench feeds different addresses to the core and pad inputs and sweeps every top address byte with every strobe combination in both owned and granted states. Synchroniser depth errors show as an acknowledge or hold request one edge early or late, and the bench counts those edges exactly.

// File: rtl/bha_pkg.sv
package bha_pkg;
  typedef enum logic [1:0] {
    ST_OWN    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_GRANT  = 2'd2,
    ST_RETURN = 2'd3
  } hold_state_t;
endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic req
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_n};
  end

  assign req = ~chain[STAGES-1];
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
  import bha_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic core_released,
  output logic hold_req,
  output logic back_n,
  output logic drv_en,
  output logic ext_sel
);
  hold_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OWN:    if (req) state_nx = ST_WAIT;
      ST_WAIT:   if (!req) state_nx = ST_OWN;
                 else if (core_released) state_nx = ST_GRANT;
      ST_GRANT:  if (!req) state_nx = ST_RETURN;
      ST_RETURN: state_nx = ST_OWN;
      default:   state_nx = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OWN;
    else        state <= state_nx;
  end

  assign hold_req = (state != ST_OWN);
  assign back_n   = (state != ST_GRANT);
  assign drv_en   = (state == ST_OWN) || (state == ST_WAIT);
  assign ext_sel  = ~drv_en;

  AST_ACK_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(back_n) |-> $past(core_released)); // R3
  AST_ACK_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !back_n |-> hold_req); // R3
  AST_HOLD_DROPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> (back_n && drv_en)); // R8
endmodule

// File: rtl/bha_cs_decode.sv
module bha_cs_decode #(
  parameter int AW  = 24,
  parameter int NCS = 4
) (
  input  logic [AW-1:0]     addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic [NCS*AW-1:0] base,
  input  logic [NCS*AW-1:0] mask,
  input  logic [NCS-1:0]    io,
  input  logic [NCS-1:0]    en,
  output logic [NCS-1:0]    cs_n
);
  logic [NCS-1:0] hit;
  logic           taken;

  for (genvar g = 0; g < NCS; g++) begin : g_region
    logic strobe_ok;
    assign strobe_ok = io[g] ? ~iorq_n : ~mreq_n;
    assign hit[g] = en[g] && strobe_ok &&
                    ((addr & mask[g*AW +: AW]) == base[g*AW +: AW]);
  end

  always_comb begin
    cs_n  = '1;
    taken = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (hit[i] && !taken) begin
        cs_n[i] = 1'b0;
        taken   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int AW          = 24,
  parameter int NCS         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              breq_n_pin,
  output logic              back_n,
  output logic              core_hold_req,
  input  logic              core_released,
  input  logic [AW-1:0]     core_addr,
  input  logic              core_mreq_n,
  input  logic              core_iorq_n,
  input  logic [AW-1:0]     pad_addr_in,
  input  logic              pad_mreq_n_in,
  input  logic              pad_iorq_n_in,
  input  logic [NCS*AW-1:0] cs_base,
  input  logic [NCS*AW-1:0] cs_mask,
  input  logic [NCS-1:0]    cs_io,
  input  logic [NCS-1:0]    cs_en,
  output logic              addr_oe,
  output logic              strobe_oe,
  output logic              data_oe,
  output logic              cmd_oe,
  output logic              dec_ext_sel,
  output logic [NCS-1:0]    cs_n
);
  logic          req;
  logic          drv_en;
  logic [AW-1:0] dec_addr;
  logic          dec_mreq_n;
  logic          dec_iorq_n;

  bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n(breq_n_pin), .req(req)
  );

  bha_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .core_released(core_released),
    .hold_req(core_hold_req), .back_n(back_n), .drv_en(drv_en),
    .ext_sel(dec_ext_sel)
  );

  assign addr_oe   = drv_en;
  assign strobe_oe = drv_en;
  assign data_oe   = drv_en;
  assign cmd_oe    = drv_en;

  assign dec_addr   = dec_ext_sel ? pad_addr_in   : core_addr;
  assign dec_mreq_n = dec_ext_sel ? pad_mreq_n_in : core_mreq_n;
  assign dec_iorq_n = dec_ext_sel ? pad_iorq_n_in : core_iorq_n;

  bha_cs_decode #(.AW(AW), .NCS(NCS)) u_dec (
    .addr(dec_addr), .mreq_n(dec_mreq_n), .iorq_n(dec_iorq_n),
    .base(cs_base), .mask(cs_mask), .io(cs_io), .en(cs_en), .cs_n(cs_n)
  );

  AST_PINS_FLOAT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !back_n |-> (!addr_oe && !strobe_oe && dec_ext_sel)); // R4
  AST_BUS_FLOAT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !back_n |-> (!data_oe && !cmd_oe)); // R6
  AST_REDRIVE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> $past(back_n)); // R7
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R5
endmodule

// File: tb/tb_bus_hold_arbiter.sv
`timescale 1ns/1ps
module tb_bus_hold_arbiter;
  localparam int AW = 24;
  localparam int NCS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic breq_n_pin = 1'b1;
  logic back_n, core_hold_req;
  logic core_released = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic core_mreq_n = 1'b1, core_iorq_n = 1'b1;
  logic [AW-1:0] pad_addr_in = '0;
  logic pad_mreq_n_in = 1'b1, pad_iorq_n_in = 1'b1;
  logic [NCS*AW-1:0] cs_base, cs_mask;
  logic [NCS-1:0] cs_io, cs_en;
  logic addr_oe, strobe_oe, data_oe, cmd_oe, dec_ext_sel;
  logic [NCS-1:0] cs_n;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_hold_arbiter #(.AW(AW), .NCS(NCS)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_pins(input string tag, input logic ack_n, input logic hold, input logic drv);
    chk({tag, " back_n"}, {31'd0, back_n}, {31'd0, ack_n});
    chk({tag, " hold_req"}, {31'd0, core_hold_req}, {31'd0, hold});
    chk({tag, " addr_oe"}, {31'd0, addr_oe}, {31'd0, drv});
    chk({tag, " strobe_oe"}, {31'd0, strobe_oe}, {31'd0, drv});
    chk({tag, " data_oe"}, {31'd0, data_oe}, {31'd0, drv});
    chk({tag, " cmd_oe"}, {31'd0, cmd_oe}, {31'd0, drv});
    chk({tag, " ext_sel"}, {31'd0, dec_ext_sel}, {31'd0, ~drv});
  endtask

  function automatic logic [NCS-1:0] model_cs(input logic [AW-1:0] a, input logic m_n, input logic i_n);
    logic [NCS-1:0] r = '1;
    for (int k = NCS - 1; k >= 0; k--) begin
      logic strobe = cs_io[k] ? !i_n : !m_n;
      if (cs_en[k] && strobe && ((a & cs_mask[k*AW +: AW]) == cs_base[k*AW +: AW]))
        r = ~(NCS'(1) << k);
    end
    return r;
  endfunction

  // sweep top address byte and strobe pairs on the selected side
  task automatic sweep(input bit from_pad);
    for (int b = 0; b < 256; b++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a = {b[7:0], 16'h5A3C ^ 16'(b * 7)};
        if (from_pad) begin
          pad_addr_in = a; pad_mreq_n_in = s[0]; pad_iorq_n_in = s[1];
          core_addr = ~a; core_mreq_n = ~s[0]; core_iorq_n = ~s[1];
        end else begin
          core_addr = a; core_mreq_n = s[0]; core_iorq_n = s[1];
          pad_addr_in = ~a; pad_mreq_n_in = ~s[0]; pad_iorq_n_in = ~s[1];
        end
        #0.1;
        chk(from_pad ? "R5 R4 cs decode from pads" : "R5 cs decode from core",
            {28'd0, cs_n}, {28'd0, model_cs(a, s[0], s[1])});
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // region 0 mem 0x00xxxx, 1 io 0x10xxxx, 2 mem 0x10xxxx, 3 mem 0x4xxxxx
    cs_base = {24'h400000, 24'h100000, 24'h100000, 24'h000000};
    cs_mask = {24'hF00000, 24'hFF0000, 24'hFF0000, 24'hFF0000};
    cs_io   = 4'b0010;
    cs_en   = 4'b1111;
    repeat (3) step();
    chk_pins("R1 in reset", 1'b1, 1'b0, 1'b1);
    rst_n = 1'b1;
    step();
    chk_pins("R1 after reset", 1'b1, 1'b0, 1'b1);

    sweep(1'b0);
    cs_en = 4'b1011;
    sweep(1'b0);
    cs_en = 4'b1111;

    // handover
    breq_n_pin = 1'b0;
    step(); chk_pins("R2 edge1", 1'b1, 1'b0, 1'b1);
    step(); chk_pins("R2 edge2", 1'b1, 1'b0, 1'b1);
    step(); chk_pins("R2 edge3", 1'b1, 1'b1, 1'b1);
    step(); chk_pins("R3 no release yet", 1'b1, 1'b1, 1'b1);
    core_released = 1'b1;
    step(); chk_pins("R3 R4 R6 granted", 1'b0, 1'b1, 1'b0);
    step(); chk_pins("R4 R6 granted hold", 1'b0, 1'b1, 1'b0);

    sweep(1'b1);
    cs_en = 4'b1101;
    sweep(1'b1);
    cs_en = 4'b1111;

    // release
    breq_n_pin = 1'b1;
    step(); chk_pins("R7 edge1", 1'b0, 1'b1, 1'b0);
    step(); chk_pins("R7 edge2", 1'b0, 1'b1, 1'b0);
    step(); chk_pins("R7 R8 edge3", 1'b1, 1'b1, 1'b0);
    step(); chk_pins("R7 R8 edge4", 1'b1, 1'b0, 1'b1);
    core_released = 1'b0;
    step(); chk_pins("R8 owned again", 1'b1, 1'b0, 1'b1);

    // withdrawal before core release
    breq_n_pin = 1'b0;
    repeat (3) step();
    chk_pins("R9 waiting", 1'b1, 1'b1, 1'b1);
    breq_n_pin = 1'b1;
    step(); chk_pins("R9 edge1", 1'b1, 1'b1, 1'b1);
    step(); chk_pins("R9 edge2", 1'b1, 1'b1, 1'b1);
    step(); chk_pins("R9 edge3", 1'b1, 1'b0, 1'b1);
    step(); chk_pins("R9 settled", 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule